// File: doc/BRIEF.md
# Linear Carry-Save Chain Multi-Operand Adder

This block adds a parameterised number of unsigned operands, `NUM_OPS` words of `OPW` bits each, and delivers the total in redundant carry-save form: a sum word plus a carry word. An optional carry-propagate adder also gives the binary total. The reduction is not a balanced tree. It is one linear chain of `NUM_OPS-2` carry-save rows. Each row is a line of full adders with no carry rippling between bit positions, and it has two regular inputs and one carry input. On the first row the carry input takes an operand. On every later row it takes the previous row's carry word, moved up by one bit. This gives a single unbroken carry path from the first row to the last.

The regular inputs of the rows take the remaining operands first, in index order. After every operand has entered, they take the partial sum words the earlier rows produced, oldest first. The last row's sum and carry words are the outputs. Every internal word is `OPW + ceil(log2(NUM_OPS))` bits wide, so the true total always fits and no bit of it is lost.

Downstream logic either uses the carry-save pair directly, weighting bit i of the carry word as 2^(i+1), or uses the binary total. A parameter chooses between a registered output with a valid flag and a purely combinational path.

Top module: `csa_chain_adder`

## Requirements
- R1: Whenever `out_valid` is 1, `(sum_word + 2*carry_word) mod 2^OUT_W` equals the unsigned sum of the operands it reports. The operand with index k occupies bits `[k*OPW +: OPW]` of `ops`.
- R2: With `HAS_CPA=1`, whenever `out_valid` is 1, `total` equals the unsigned sum of the operands it reports.
- R3: `OUT_W = OPW + ceil(log2(NUM_OPS))`. When every operand bit is 1, the result is exactly `NUM_OPS*(2^OPW-1)` and nothing wraps.
- R4: With `REG_OUT=1`, the operands sampled at a rising edge with `in_valid=1` appear on all outputs after that edge, and `out_valid` equals `in_valid` delayed by one edge. Before that edge the outputs still show the previous result. With `REG_OUT=0`, the results follow the operands in the same cycle and `out_valid` equals `in_valid`.
- R5: With `REG_OUT=1`, a rising edge with `rst_n=0` clears `out_valid`, `sum_word`, `carry_word` and `total` to 0, whatever `in_valid` and `ops` hold.
- R6: With `REG_OUT=1`, an edge with `in_valid=0` leaves `sum_word`, `carry_word` and `total` unchanged, even if `ops` changes.
- R7: All-zero operands give `sum_word`, `carry_word` and `total` all equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on `ops` are to be added |
| ops | input | NUM_OPS*OPW | Packed operands, index k at bits [k*OPW +: OPW] |
| out_valid | output | 1 | Outputs hold a result |
| sum_word | output | OUT_W | Final carry-save sum word |
| carry_word | output | OUT_W | Final carry word, bit i weighted 2^(i+1) |
| total | output | OUT_W | Binary total (0 when HAS_CPA=0) |

## Verification
In the registered configuration, the operands driven on a falling edge are sampled at the next rising edge, and the sum pair, total and valid flag are due one time step after that edge. The bench compares them there. It also checks, just after the new operands are driven, that the previous result is still present. The combinational configuration is compared one time step after its operands change, within the same cycle. The reset and hold checks are read one step after the edge that must clear or keep the register contents.

// File: rtl/csa_chain_pkg.sv
// Package csa_chain_pkg
// Shared helpers for the linear carry-save chain adder. Assumes NOP >= 3.
package csa_chain_pkg;

    // Maps the j-th regular input slot of rows 1.. onto a word index.
    // Indices below nop are operands; nop+k is the sum word of row k.
    function automatic int slot_src(input int slot, input int nop);
        if (slot < nop - 3) begin
            return 3 + slot;
        end
        return nop + (slot - (nop - 3));
    endfunction

endpackage

// File: rtl/csa_row.sv
// Module csa_row
// One carry-save row: W independent full adders, no carry passed between
// bit positions. The carry output is unshifted (bit i has weight 2^(i+1)).
module csa_row #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] ci,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Full adder: parity for sum, majority for carry.
        assign s[i] = a[i] ^ b[i] ^ ci[i];
        assign c[i] = (a[i] & b[i]) | (a[i] & ci[i]) | (b[i] & ci[i]);
    end

endmodule

// File: rtl/csa_linear_array.sv
// Module csa_linear_array
// Reduces NOP operands of N bits to one carry-save pair of W bits using
// NOP-2 chained rows. Row 0 takes operands 0,1,2. Each later row takes the
// previous row's carry word shifted up one bit on its carry input, and on its
// regular inputs the leftover operands in order, then earlier partial sums
// oldest first. Assumes W is wide enough for the full total.
module csa_linear_array
    import csa_chain_pkg::*;
#(
    parameter int N   = 8,
    parameter int NOP = 5,
    parameter int W   = N + $clog2(NOP)
) (
    input  logic [NOP-1:0][N-1:0] ops,
    output logic [W-1:0]          sum_o,
    output logic [W-1:0]          carry_o
);

    localparam int STAGES = NOP - 2;

    logic [W-1:0] opx [NOP];
    logic [W-1:0] ps  [STAGES];
    logic [W-1:0] cy  [STAGES];

    for (genvar g = 0; g < NOP; g++) begin : g_ext
        // Zero-extend each operand to the internal width.
        assign opx[g] = W'(ops[g]);
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic [W-1:0] a_in;
        logic [W-1:0] b_in;
        logic [W-1:0] ci_in;

        if (k == 0) begin : g_head
            // First row: all three inputs are operands.
            assign a_in  = opx[0];
            assign b_in  = opx[1];
            assign ci_in = opx[2];
        end else begin : g_link
            localparam int SA = slot_src(2 * (k - 1), NOP);
            localparam int SB = slot_src(2 * (k - 1) + 1, NOP);

            if (SA < NOP) begin : g_a_op
                assign a_in = opx[SA];
            end else begin : g_a_ps
                assign a_in = ps[SA - NOP];
            end

            if (SB < NOP) begin : g_b_op
                assign b_in = opx[SB];
            end else begin : g_b_ps
                assign b_in = ps[SB - NOP];
            end

            // Carry-to-carry link with a zero at the least significant bit.
            assign ci_in = cy[k - 1] << 1;
        end

        csa_row #(.W(W)) row_i (
            .a (a_in),
            .b (b_in),
            .ci(ci_in),
            .s (ps[k]),
            .c (cy[k])
        );
    end

    assign sum_o   = ps[STAGES - 1];
    assign carry_o = cy[STAGES - 1];

endmodule

// File: rtl/cpa_adder.sv
// Module cpa_adder
// Plain carry-propagate adder converting the carry-save pair to binary.
// Expects the carry word already shifted to its true weight.
module cpa_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    assign y = a + b;

endmodule

// File: rtl/out_reg.sv
// Module out_reg
// Optional output stage. REG=1: results captured on in_valid, held otherwise,
// cleared by synchronous active-low reset. REG=0: straight wires.
module out_reg #(
    parameter int W   = 8,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] d_sum,
    input  logic [W-1:0] d_carry,
    input  logic [W-1:0] d_total,
    output logic         q_valid,
    output logic [W-1:0] q_sum,
    output logic [W-1:0] q_carry,
    output logic [W-1:0] q_total
);

    if (REG) begin : g_reg
        // Capture a new result on valid input, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_valid <= 1'b0;
                q_sum   <= '0;
                q_carry <= '0;
                q_total <= '0;
            end else begin
                q_valid <= in_valid;
                if (in_valid) begin
                    q_sum   <= d_sum;
                    q_carry <= d_carry;
                    q_total <= d_total;
                end
            end
        end
    end else begin : g_comb
        assign q_valid = in_valid;
        assign q_sum   = d_sum;
        assign q_carry = d_carry;
        assign q_total = d_total;
    end

endmodule

// File: rtl/csa_chain_adder.sv
// Module csa_chain_adder
// Top: multi-operand unsigned adder built on a linear carry-save chain, with
// optional binary conversion and optional output register. Requires
// NUM_OPS >= 3 and OPW >= 1.
module csa_chain_adder #(
    parameter int OPW     = 8,
    parameter int NUM_OPS = 5,
    parameter bit REG_OUT = 1'b1,
    parameter bit HAS_CPA = 1'b1,
    localparam int OUT_W  = OPW + $clog2(NUM_OPS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [NUM_OPS-1:0][OPW-1:0]  ops,
    output logic                         out_valid,
    output logic [OUT_W-1:0]             sum_word,
    output logic [OUT_W-1:0]             carry_word,
    output logic [OUT_W-1:0]             total
);

    logic [OUT_W-1:0] chain_sum;
    logic [OUT_W-1:0] chain_carry;
    logic [OUT_W-1:0] bin_total;

    csa_linear_array #(
        .N  (OPW),
        .NOP(NUM_OPS),
        .W  (OUT_W)
    ) chain_i (
        .ops    (ops),
        .sum_o  (chain_sum),
        .carry_o(chain_carry)
    );

    if (HAS_CPA) begin : g_cpa
        logic [OUT_W-1:0] carry_shifted;
        // Give the final carry word its true weight before conversion.
        assign carry_shifted = chain_carry << 1;
        cpa_adder #(.W(OUT_W)) cpa_i (
            .a(chain_sum),
            .b(carry_shifted),
            .y(bin_total)
        );
    end else begin : g_no_cpa
        assign bin_total = '0;
    end

    out_reg #(
        .W  (OUT_W),
        .REG(REG_OUT)
    ) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .d_sum   (chain_sum),
        .d_carry (chain_carry),
        .d_total (bin_total),
        .q_valid (out_valid),
        .q_sum   (sum_word),
        .q_carry (carry_word),
        .q_total (total)
    );

endmodule

// File: rtl/csa_chain_adder_chk.sv
// Module csa_chain_adder_chk
// Property checker bound to every csa_chain_adder instance. Compares the
// outputs with a behavioural sum of the operands.
module csa_chain_adder_chk #(
    parameter int OPW     = 8,
    parameter int NUM_OPS = 5,
    parameter bit REG_OUT = 1'b1,
    parameter bit HAS_CPA = 1'b1,
    parameter int OUT_W   = OPW + $clog2(NUM_OPS)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic [NUM_OPS-1:0][OPW-1:0]  ops,
    input logic                         out_valid,
    input logic [OUT_W-1:0]             sum_word,
    input logic [OUT_W-1:0]             carry_word,
    input logic [OUT_W-1:0]             total
);

    logic [OUT_W-1:0] ref_sum;
    logic [OUT_W-1:0] cs_value;

    // Behavioural reference: plain loop over the operands.
    always_comb begin
        ref_sum = '0;
        for (int k = 0; k < NUM_OPS; k++) begin
            ref_sum = ref_sum + OUT_W'(ops[k]);
        end
    end

    assign cs_value = sum_word + (carry_word << 1);

    if (REG_OUT) begin : g_reg_props
        a_r1_cs_pair: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (cs_value == $past(ref_sum)));

        if (HAS_CPA) begin : g_tot
            a_r2_total: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (total == $past(ref_sum)));
        end

        a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (out_valid == $past(in_valid)));

        a_r5_reset_clear: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && sum_word == '0 && carry_word == '0 && total == '0));

        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(sum_word) && $stable(carry_word) && $stable(total)));
    end else begin : g_comb_props
        a_r1_cs_pair_c: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (cs_value == ref_sum));

        if (HAS_CPA) begin : g_tot
            a_r2_total_c: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (total == ref_sum));
        end
    end

endmodule

bind csa_chain_adder csa_chain_adder_chk #(
    .OPW    (OPW),
    .NUM_OPS(NUM_OPS),
    .REG_OUT(REG_OUT),
    .HAS_CPA(HAS_CPA),
    .OUT_W  (OUT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ops       (ops),
    .out_valid (out_valid),
    .sum_word  (sum_word),
    .carry_word(carry_word),
    .total     (total)
);

// File: tb/csa_chain_adder_tb_top.sv
// Bench: exhaustive sweep of a registered 4x3-bit instance and a
// combinational 5x2-bit instance, expected sums computed arithmetically.
module csa_chain_adder_tb_top;

    localparam int AW = 3, AN = 4, AO = AW + $clog2(AN);
    localparam int BW = 2, BN = 5, BO = BW + $clog2(BN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [AN-1:0][AW-1:0] ops_a = '0;
    logic [BN-1:0][BW-1:0] ops_b = '0;

    logic          a_vld, b_vld;
    logic [AO-1:0] a_sum, a_cy, a_tot;
    logic [BO-1:0] b_sum, b_cy, b_tot;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    csa_chain_adder #(.OPW(AW), .NUM_OPS(AN), .REG_OUT(1'b1), .HAS_CPA(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ops(ops_a),
        .out_valid(a_vld), .sum_word(a_sum), .carry_word(a_cy), .total(a_tot)
    );

    csa_chain_adder #(.OPW(BW), .NUM_OPS(BN), .REG_OUT(1'b0), .HAS_CPA(1'b1)) dut_c (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ops(ops_b),
        .out_valid(b_vld), .sum_word(b_sum), .carry_word(b_cy), .total(b_tot)
    );

    function automatic int sum_a(input logic [AN-1:0][AW-1:0] v);
        int s = 0;
        for (int k = 0; k < AN; k++) s += int'(v[k]);
        return s;
    endfunction

    function automatic int sum_b(input logic [BN-1:0][BW-1:0] v);
        int s = 0;
        for (int k = 0; k < BN; k++) s += int'(v[k]);
        return s;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int prev_tot;
        int exp_a;
        int exp_b;
        int hold_sum;
        int hold_cy;
        // R5: reset dominates a valid input.
        in_valid = 1'b1;
        ops_a = '1;
        repeat (3) @(posedge clk);
        #1;
        chk("R5 reset out_valid", int'(a_vld), 0);
        chk("R5 reset sum_word", int'(a_sum), 0);
        chk("R5 reset carry_word", int'(a_cy), 0);
        chk("R5 reset total", int'(a_tot), 0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        ops_a = '0;

        prev_tot = 0;
        for (int i = 0; i < (1 << (AN * AW)); i++) begin
            @(negedge clk);
            ops_a = (AN * AW)'(i);
            ops_b = (BN * BW)'(i);
            in_valid = 1'b1;
            exp_a = sum_a(ops_a);
            exp_b = sum_b(ops_b);
            #1;
            // R4: combinational instance follows in the same cycle.
            chk("R4 comb out_valid", int'(b_vld), 1);
            chk("R2 comb total", int'(b_tot), exp_b);
            chk("R1 comb carry-save pair", int'(BO'(b_sum + (b_cy << 1))), exp_b);
            // R4: registered instance still shows the previous result.
            if (i > 0) chk("R4 reg before edge", int'(a_tot), prev_tot);
            @(posedge clk);
            #1;
            chk("R4 reg out_valid", int'(a_vld), 1);
            chk("R2 reg total", int'(a_tot), exp_a);
            chk("R1 reg carry-save pair", int'(AO'(a_sum + (a_cy << 1))), exp_a);
            if (i == 0) begin
                chk("R7 zero sum_word", int'(a_sum), 0);
                chk("R7 zero carry_word", int'(a_cy), 0);
                chk("R7 zero total", int'(a_tot), 0);
            end
            if (i == (1 << (BN * BW)) - 1) begin
                chk("R3 comb all ones", int'(b_tot), BN * ((1 << BW) - 1));
            end
            if (i == (1 << (AN * AW)) - 1) begin
                chk("R3 reg all ones", int'(a_tot), AN * ((1 << AW) - 1));
            end
            prev_tot = int'(a_tot);
        end

        // R6: idle input leaves the registered result untouched.
        hold_sum = int'(a_sum);
        hold_cy = int'(a_cy);
        @(negedge clk);
        in_valid = 1'b0;
        ops_a = (AN * AW)'(12'h5A3);
        ops_b = (BN * BW)'(10'h155);
        #1;
        chk("R4 comb out_valid idle", int'(b_vld), 0);
        repeat (3) begin
            @(posedge clk);
            #1;
            chk("R4 reg out_valid idle", int'(a_vld), 0);
            chk("R6 hold total", int'(a_tot), AN * ((1 << AW) - 1));
            chk("R6 hold sum_word", int'(a_sum), hold_sum);
            chk("R6 hold carry_word", int'(a_cy), hold_cy);
        end

        // R5: mid-run reset with valid input clears everything.
        @(negedge clk);
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R5 midrun out_valid", int'(a_vld), 0);
        chk("R5 midrun total", int'(a_tot), 0);
        chk("R5 midrun sum_word", int'(a_sum), 0);
        chk("R5 midrun carry_word", int'(a_cy), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R2 after reset total", int'(a_tot), sum_a(ops_a));

        done = 1'b1;
        finish_run();
    end

endmodule